// File: doc/BRIEF.md
# ACPI Power Management Timer

This block is a free-running up-counter used by platform firmware and the operating system as a fixed-rate time reference. It runs from a 3.579545 MHz timebase, advances only while the system reports that it is in its working state, and keeps its value when the timebase stops. Only the master reset brings it back to zero. Software reads the count through four byte-wide read-only registers in a small 16-byte I/O window. Reading the low byte freezes the two upper bytes, so a sequence of byte reads yields one coherent value.

Each time the most significant count bit changes, in either direction, the block sets a sticky timer status flag. An enable bit gates that flag onto a level-sensitive system control interrupt output. Software clears the flag by writing a one to it. The counter width is a parameter (24 by default). Narrower instances zero-fill the unused upper register bits and watch their own top bit.

Top module: `pm_timer_top`

## Requirements
- R1: While `working_i` is 1, the count rises by exactly one on each clock edge. While `working_i` is 0, the count holds.
- R2: A synchronous active-low master reset clears the count, the status flag, the enable bit, the read snapshot and `reg_rdata` to zero.
- R3: If the clock stops and later restarts without a reset, counting resumes from the held value.
- R4: A read strobe at offset 0x8 returns count bits 7:0, at 0x9 bits 15:8 and at 0xA bits 23:16, with bit 16 in data bit 0. Offset 0xB and every unmapped offset return 0x00. `reg_rdata` is valid in the cycle after the strobe and holds until the next strobe.
- R5: A read of offset 0x8 captures count bits 23:8 in the same cycle. Reads of 0x9 and 0xA then return that captured value and not the live count.
- R6: Writes to offsets 0x8 to 0xB change neither the count nor the snapshot.
- R7: The status flag (offset 0x0, data bit 0) is set one cycle after the counter MSB changes from 0 to 1 or from 1 to 0.
- R8: Writing 1 to bit 0 of offset 0x0 clears the status flag. Writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag at 1.
- R9: The enable bit is read/write at bit 0 of offset 0x2. `sci_o` is 1 exactly while both the status flag and the enable bit are 1, and clearing either one drops it in the next cycle.
- R10: The count wraps from all ones to zero with no extra flag. The MSB's fall at the wrap sets the status flag like any other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz timebase; may stop |
| rst_n | input | 1 | Master reset, synchronous, active low |
| working_i | input | 1 | 1 while the system is in the working state |
| reg_addr | input | 4 | Byte offset in the register window |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| sci_o | output | 1 | Level interrupt request |

## Verification
On every cycle the bound assertions check that the count steps by one or holds according to `working_i`, including across the wrap. They also check that any change of the top count bit is followed by a set status flag, that a one-write with no competing set clears the flag while a zero-write keeps it, that the interrupt never rises without both the flag and the enable, and that the reserved byte reads zero. The bench scenarios show what a single-cycle property cannot: the byte ordering and the frozen upper bytes over a multi-read sequence, ignored writes observed through later reads, a resumed count after the clock has stopped, and the collision of a set with a clear at the exact edge where the MSB rises. They also cover the fall at the wrap, which takes a full counter period to reach.

// File: rtl/pm_tmr_pkg.sv
// Package: register offsets, the read-select type and the address decode
// shared by the power management timer modules.
// Assumes a 4-bit byte offset inside the block's own register window.
package pm_tmr_pkg;

    localparam int VIEW_W = 24;  // visible width of the count in the register window

    localparam logic [3:0] OFS_STS     = 4'h0;
    localparam logic [3:0] OFS_EN      = 4'h2;
    localparam logic [3:0] OFS_CNT_LO  = 4'h8;
    localparam logic [3:0] OFS_CNT_MID = 4'h9;
    localparam logic [3:0] OFS_CNT_HI  = 4'hA;
    localparam logic [3:0] OFS_CNT_RSV = 4'hB;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_STS,
        SEL_EN,
        SEL_LO,
        SEL_MID,
        SEL_HI
    } rd_sel_e;

    // Map an offset to the register it reads; reserved and unmapped give zero.
    function automatic rd_sel_e decode_rd(input logic [3:0] ofs);
        rd_sel_e s;
        case (ofs)
            OFS_STS:     s = SEL_STS;
            OFS_EN:      s = SEL_EN;
            OFS_CNT_LO:  s = SEL_LO;
            OFS_CNT_MID: s = SEL_MID;
            OFS_CNT_HI:  s = SEL_HI;
            default:     s = SEL_ZERO;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pm_tmr_counter.sv
// Module: pm_tmr_counter
// Free-running binary up-counter that advances once per clock while run is
// high and wraps silently from all ones to zero.
// Assumes: clk is the timer timebase and may stop; the value is then simply
// held by the flops, so only rst_n ever returns it to zero.
module pm_tmr_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: master reset clears, otherwise step while the system is working.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/pm_tmr_flags.sv
// Module: pm_tmr_flags
// Detects every change of the counter MSB, keeps the sticky status flag and
// the enable bit, and forms the level interrupt from the two.
// Assumes: the write strobe lasts one cycle; only data bit 0 is meaningful.
module pm_tmr_flags
    import pm_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       msb,
    input  logic       wr,
    input  logic [3:0] addr,
    input  logic       wbit,
    output logic       sts,
    output logic       en,
    output logic       sci
);

    logic msb_q;
    logic msb_flip;
    logic sts_clr;
    logic en_wr;

    // Purpose: remember the previous MSB so both directions of change are seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= 1'b0;
        end else begin
            msb_q <= msb;
        end
    end

    // Purpose: decode the edge and the two register writes.
    always_comb begin
        msb_flip = msb ^ msb_q;
        sts_clr  = wr && (addr == OFS_STS) && wbit;
        en_wr    = wr && (addr == OFS_EN);
    end

    // Purpose: sticky status; a new edge wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (msb_flip) begin
            sts <= 1'b1;
        end else if (sts_clr) begin
            sts <= 1'b0;
        end
    end

    // Purpose: read/write interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (en_wr) begin
            en <= wbit;
        end
    end

    // Purpose: level interrupt request.
    always_comb begin
        sci = sts & en;
    end

endmodule

// File: rtl/pm_tmr_regfile.sv
// Module: pm_tmr_regfile
// Byte-wide read path of the timer window: the live low byte, a snapshot of
// the upper bytes taken when the low byte is read, and the flag registers.
// Assumes: CNT_W is between 9 and 24; the unused upper bits read as zero.
module pm_tmr_regfile
    import pm_tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [3:0]       addr,
    input  logic [CNT_W-1:0] count,
    input  logic             sts,
    input  logic             en,
    output logic [7:0]       rdata
);

    localparam int SNAP_W = VIEW_W - 8;

    logic [VIEW_W-1:0] view;
    logic [SNAP_W-1:0] snap;
    rd_sel_e           sel;
    logic [7:0]        rd_mux;

    // Purpose: widen the count to the fixed register view and decode the offset.
    always_comb begin
        view = VIEW_W'(count);
        sel  = decode_rd(addr);
    end

    // Purpose: freeze the upper bytes whenever the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (rd && (sel == SEL_LO)) begin
            snap <= view[VIEW_W-1:8];
        end
    end

    // Purpose: pick the byte for the current read offset.
    always_comb begin
        case (sel)
            SEL_STS: rd_mux = {7'd0, sts};
            SEL_EN:  rd_mux = {7'd0, en};
            SEL_LO:  rd_mux = view[7:0];
            SEL_MID: rd_mux = snap[7:0];
            SEL_HI:  rd_mux = snap[15:8];
            default: rd_mux = 8'h00;
        endcase
    end

    // Purpose: register the read data; it holds until the next read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else if (rd) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/pm_timer_top.sv
// Module: pm_timer_top
// Power management timer: counter, MSB-change status and interrupt, and a
// byte-wide register window.
// Assumes: clk is the timer timebase; register accesses are one-cycle strobes
// on the same clock; rst_n is the master reset.
module pm_timer_top #(
    parameter int CNT_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       working_i,
    input  logic [3:0] reg_addr,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sci_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             tmr_sts;
    logic             tmr_en;
    logic             wdata_unused;

    // Purpose: only data bit 0 carries meaning in this window.
    always_comb begin
        wdata_unused = ^reg_wdata[7:1];
    end

    pm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (working_i),
        .count (cnt_q)
    );

    pm_tmr_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .msb   (cnt_q[CNT_W-1]),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wbit  (reg_wdata[0]),
        .sts   (tmr_sts),
        .en    (tmr_en),
        .sci   (sci_o)
    );

    pm_tmr_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .count (cnt_q),
        .sts   (tmr_sts),
        .en    (tmr_en),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/pm_timer_checker.sv
// Module: pm_timer_checker
// Cycle-by-cycle properties of the power management timer, bound to the top.
module pm_timer_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             working_i,
    input logic [3:0]       reg_addr,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic             wbit,
    input logic [7:0]       reg_rdata,
    input logic             sci_o,
    input logic [CNT_W-1:0] count,
    input logic             sts,
    input logic             en
);

    localparam int MSB = CNT_W - 1;

    // R1: one step per working cycle, wrap included
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        working_i |=> ((count - $past(count)) == CNT_W'(1)));

    // R1: no movement outside the working state
    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !working_i |=> $stable(count));

    // R7, R10: any MSB change leaves the flag set
    a_r7_msb_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (count[MSB] != $past(count[MSB])) |=> sts);

    // R8: a one-write with no competing edge clears the flag
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h0 && wbit && count[MSB] == $past(count[MSB])) |=> !sts);

    // R8: a zero-write leaves the flag alone
    a_r8_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h0 && !wbit && sts) |=> sts);

    // R9: no interrupt without the enable
    a_r9_sci_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !sci_o);

    // R9: no interrupt without the flag
    a_r9_sci_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
        sci_o |-> sts);

    // R4: reserved byte reads zero
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 4'hB) |=> (reg_rdata == 8'h00));

endmodule

bind pm_timer_top pm_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .working_i (working_i),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .wbit      (reg_wdata[0]),
    .reg_rdata (reg_rdata),
    .sci_o     (sci_o),
    .count     (cnt_q),
    .sts       (tmr_sts),
    .en        (tmr_en)
);

// File: tb/pm_timer_top_test.sv
// Scoreboard bench: read tasks push expected bytes, a monitor pops and compares.
module pm_timer_top_test;

    localparam int W = 17;
    localparam logic [23:0] MASK = (24'd1 << W) - 24'd1;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       working_i = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sci_o;

    int tests = 0;
    int fails = 0;

    logic [23:0] m = '0;      // model count
    logic [15:0] snap_m = '0; // model snapshot
    logic        sts_e = 1'b0;
    logic        en_e  = 1'b0;
    logic        rd_q  = 1'b0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    pm_timer_top #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .working_i (working_i),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sci_o     (sci_o)
    );

    always begin
        #5;
        if (clk_run) clk = ~clk;
    end

    // Reference count built from R1/R2/R10
    always @(posedge clk) begin
        if (!rst_n) m <= '0;
        else if (working_i) m <= (m + 24'd1) & MASK;
        rd_q <= reg_rd;
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Monitor: compares read data one cycle after each strobe
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(reg_rdata === e, t, reg_rdata, e);
        end
    end

    task automatic rd(input logic [3:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        case (a)
            4'h0: e = {7'd0, sts_e};
            4'h2: e = {7'd0, en_e};
            4'h8: begin e = m[7:0]; snap_m = m[23:8]; end
            4'h9: e = snap_m[7:0];
            4'hA: e = snap_m[15:8];
            default: e = 8'h00;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_addr = a;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_to(input logic [23:0] target);
        @(negedge clk);
        working_i = 1'b1;
        while (m != target) @(negedge clk);
        working_i = 1'b0;
    endtask

    task automatic step_one();
        @(negedge clk);
        working_i = 1'b1;
        @(negedge clk);
        working_i = 1'b0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        rd(4'h8, "R2 low byte after reset");
        rd(4'h9, "R2 mid byte after reset");
        rd(4'hA, "R2 high byte after reset");
        rd(4'h0, "R2 status after reset");
        rd(4'h2, "R2 enable after reset");
        check(sci_o === 1'b0, "R2 sci after reset", sci_o, 0);

        // R1: counting and holding
        @(negedge clk); working_i = 1'b1;
        repeat (100) @(negedge clk);
        working_i = 1'b0;
        rd(4'h8, "R1 count after run");
        repeat (50) @(negedge clk);
        rd(4'h8, "R1 count held while not working");
        rd(4'hB, "R4 reserved byte");
        rd(4'h5, "R4 unmapped offset");

        // R5: snapshot survives a carry into the upper bytes
        @(negedge clk); working_i = 1'b1;
        rd(4'h8, "R5 low byte live");
        repeat (300) @(negedge clk);
        rd(4'h9, "R5 mid byte from snapshot");
        rd(4'hA, "R5 high byte from snapshot");
        working_i = 1'b0;
        rd(4'h8, "R4 low byte");
        rd(4'h9, "R4 mid byte");

        // R6: writes to the timer bytes are ignored
        wr(4'h8, 8'hFF); wr(4'h9, 8'hFF); wr(4'hA, 8'hFF); wr(4'hB, 8'hFF);
        rd(4'h9, "R6 snapshot after writes");
        rd(4'h8, "R6 low byte after writes");
        rd(4'h9, "R6 mid byte after writes");

        // R3: clock stops and restarts
        @(negedge clk); working_i = 1'b1;
        repeat (20) @(negedge clk);
        clk_run = 1'b0;
        #2000;
        clk_run = 1'b1;
        repeat (20) @(negedge clk);
        working_i = 1'b0;
        rd(4'h8, "R3 count resumes after clock stop");
        rd(4'h9, "R3 mid byte after clock stop");

        // R7/R8: MSB rises; a clear in the same cycle loses to the set
        run_to(24'h0FFFF);
        rd(4'h0, "R7 status before MSB change");
        @(negedge clk);
        working_i = 1'b1;
        @(negedge clk);
        working_i = 1'b0;
        reg_addr = 4'h0; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        sts_e = 1'b1;
        rd(4'h0, "R8 set wins over clear, R7 rising MSB");
        rd(4'h8, "R4 low byte at MSB");
        rd(4'hA, "R4 bit16 at data bit 0");
        check(sci_o === 1'b0, "R9 sci low while disabled", sci_o, 0);
        wr(4'h0, 8'h00);
        rd(4'h0, "R8 zero write keeps status");
        wr(4'h2, 8'h01);
        en_e = 1'b1;
        check(sci_o === 1'b1, "R9 sci with status and enable", sci_o, 1);
        rd(4'h2, "R9 enable readback");
        wr(4'h2, 8'h00);
        check(sci_o === 1'b0, "R9 sci drops with enable", sci_o, 0);
        wr(4'h2, 8'h01);
        wr(4'h0, 8'h01);
        sts_e = 1'b0;
        check(sci_o === 1'b0, "R9 sci drops with status clear", sci_o, 0);
        rd(4'h0, "R8 one write clears status");

        // R10: wrap to zero sets the flag through the falling MSB
        run_to(MASK);
        rd(4'h0, "R10 no flag before wrap");
        step_one();
        @(negedge clk);
        sts_e = 1'b1;
        rd(4'h0, "R10 R7 falling MSB sets status");
        rd(4'h8, "R10 low byte after wrap");
        rd(4'h9, "R10 mid byte after wrap");
        rd(4'hA, "R10 high byte after wrap");
        check(sci_o === 1'b1, "R9 sci after wrap", sci_o, 1);

        // R2: master reset mid-run
        @(negedge clk); working_i = 1'b1;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        working_i = 1'b0;
        sts_e = 1'b0; en_e = 1'b0; snap_m = '0;
        rd(4'h9, "R2 snapshot cleared by reset");
        rd(4'h8, "R2 count cleared by reset");
        rd(4'h0, "R2 status cleared by reset");
        rd(4'h2, "R2 enable cleared by reset");
        check(sci_o === 1'b0, "R2 sci after reset", sci_o, 0);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule